// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Promotion

This block collects every interrupt source of a small 8-bit microcontroller and decides which one the CPU should service next. Twenty-one sources are ranked in a fixed order. The top five (external reset, clock-monitor fault, watchdog fault, illegal-opcode trap and software trap) are always accepted. The non-maskable pin is gated by the X mask bit. The general interrupt pin and fourteen peripheral lines are gated by the I mask bit, and each peripheral line also has its own local enable. Software can move any one of the fifteen maskable sources to the top of the maskable group, but it can only do so while I is set.

The block holds the CPU's I and X mask bits itself, so that it can enforce their rules. Accepting the non-maskable pin sets both bits. Accepting any maskable source sets I. A software write can lower X but can never raise it. The interrupt pin can be level sensitive (the default) or sensitive to a falling edge. The winning source is offered on a valid/ready pair together with its rank and its 16-bit vector-table address. The CPU takes the request by raising `req_ready` while `req_valid` is high; that cycle is the acceptance. There is no other back-pressure. While `req_valid` is high and `req_ready` is low, the offered rank can move to a more urgent source that becomes eligible. The payload is binding only in the cycle of the transfer.

Top module: `intc_prio`

## Requirements
- R1: After `rst_n` is released, `req_valid` is 0, `mask_i` is 1 and `mask_x` is 1, the promotion register holds rank 6 (so the default order applies) and the interrupt pin is level sensitive.
- R2: The vector address is 0xFFFE minus twice the rank. Rank 0 gives 0xFFFE, rank 1 gives 0xFFFC and rank 6 gives 0xFFF2. The lowest rank, 20, gives 0xFFD6.
- R3: Ranks from most to least urgent are: 0 external reset (`rst_pin_n` low), 1 clock monitor, 2 watchdog, 3 illegal opcode, 4 software trap, 5 non-maskable pin (`xirq_n` low), 6 interrupt pin, and 7 to 20 for `per_req[0]` to `per_req[13]`. When several sources are eligible, the lowest-numbered one is offered.
- R4: Ranks 6 to 20 are eligible only while `mask_i` is 0. A peripheral line also needs its `per_en` bit set. The interrupt pin has no local enable.
- R5: `prom_wr` loads `prom_wd` into the promotion register only while `mask_i` is 1. If the named rank lies in 6..20 and is eligible, it is offered ahead of all other maskable ranks, but never ahead of ranks 0 to 5.
- R6: A promotion value outside 6..20 promotes nothing, and the order of R3 applies.
- R7: Rank 5 is eligible only while `mask_x` is 0. A `ccr_wr` write can clear X but never set it, so a written 1 leaves X at 0.
- R8: On acceptance, I is set for every rank. X is also set when the accepted rank is 0, 1, 2 or 5.
- R9: Ranks 0 to 4 are offered whatever the values of I and X.
- R10: In level mode, the interrupt pin requests whenever `irq_n` is low and requests again at once after it is accepted.
- R11: With `sense_wd`=1 written (edge mode), a falling edge of `irq_n` is latched at the next clock and requests from then on. Accepting rank 6 clears the latch, and no new request comes until `irq_n` rises and falls again.
- R12: A transfer happens only when `req_valid` and `req_ready` are both high. A one-cycle pulse on `illop_stb` or `swi_stb` is held pending from the next clock until its rank is transferred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| rst_pin_n | input | 1 | External reset request, active low, level |
| clkmon_fail | input | 1 | Clock-monitor fault, level |
| cop_fail | input | 1 | Watchdog fault, level |
| illop_stb | input | 1 | Illegal-opcode pulse |
| swi_stb | input | 1 | Software-trap pulse |
| xirq_n | input | 1 | Non-maskable pin, active low, level |
| irq_n | input | 1 | Maskable interrupt pin, active low |
| per_req | input | NUM_PERIPH | Peripheral request lines |
| per_en | input | NUM_PERIPH | Peripheral local enables |
| ccr_wr | input | 1 | Write strobe for the mask bits |
| ccr_i_wd | input | 1 | New I value |
| ccr_x_wd | input | 1 | New X value (can only clear) |
| prom_wr | input | 1 | Promotion register write strobe |
| prom_wd | input | 5 | Rank to promote |
| sense_wr | input | 1 | Interrupt-pin sense write strobe |
| sense_wd | input | 1 | 1 = falling edge, 0 = level |
| req_valid | output | 1 | An eligible source is offered |
| req_ready | input | 1 | CPU takes the offered source |
| req_src | output | 5 | Rank of the offered source |
| req_vec | output | 16 | Vector-table address of the offered source |
| mask_i | output | 1 | Current I mask bit |
| mask_x | output | 1 | Current X mask bit |

## Verification
The bench uses the default parameters: fourteen peripheral lines and a top vector of 0xFFFE. With these, every rank from 0 to 20 exists, so the real vector addresses can be checked at both ends of the table, and a promoted rank near the bottom can be shown overtaking a rank near the top of the maskable group. At this size the bench can also cover the locked promotion write, an out-of-range promotion code, the one-way X bit, and both sense modes of the interrupt pin.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int unsigned SRC_W     = 5;
  localparam int unsigned RK_RESET  = 0;
  localparam int unsigned RK_CLKMON = 1;
  localparam int unsigned RK_COP    = 2;
  localparam int unsigned RK_ILLOP  = 3;
  localparam int unsigned RK_SWI    = 4;
  localparam int unsigned RK_XIRQ   = 5;
  localparam int unsigned RK_IRQ    = 6;
  localparam int unsigned RK_PER0   = 7;

  typedef logic [SRC_W-1:0] rank_t;

  // vector entry address: each rank owns two bytes counting down from the top
  function automatic logic [15:0] vec_of(input logic [15:0] top, input rank_t r);
    return top - {{(15-SRC_W){1'b0}}, r, 1'b0};
  endfunction
endpackage

// File: rtl/intc_pending.sv
module intc_pending
  import intc_pkg::*;
#(
  parameter int unsigned NUM_PERIPH = 14,
  localparam int unsigned NUM_SRC = RK_PER0 + NUM_PERIPH
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rst_pin_n,
  input  logic                  clkmon_fail,
  input  logic                  cop_fail,
  input  logic                  illop_stb,
  input  logic                  swi_stb,
  input  logic                  xirq_n,
  input  logic                  irq_n,
  input  logic [NUM_PERIPH-1:0] per_req,
  input  logic [NUM_PERIPH-1:0] per_en,
  input  logic                  sense_edge,
  input  logic                  ack,
  input  rank_t                 ack_src,
  output logic [NUM_SRC-1:0]    pend
);
  logic illop_q, swi_q, irq_prev_q, irq_edge_q;
  logic ack_illop, ack_swi, ack_irq;

  assign ack_illop = ack && (ack_src == rank_t'(RK_ILLOP));
  assign ack_swi   = ack && (ack_src == rank_t'(RK_SWI));
  assign ack_irq   = ack && (ack_src == rank_t'(RK_IRQ));

  // trap pulses are held until their rank is taken; a new pulse wins over a clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      illop_q <= 1'b0;
      swi_q   <= 1'b0;
    end else begin
      illop_q <= illop_stb | (illop_q & ~ack_illop);
      swi_q   <= swi_stb | (swi_q & ~ack_swi);
    end
  end

  // falling-edge capture for the interrupt pin
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_prev_q <= 1'b1;
      irq_edge_q <= 1'b0;
    end else begin
      irq_prev_q <= irq_n;
      if (!sense_edge)
        irq_edge_q <= 1'b0;
      else if (irq_prev_q && !irq_n)
        irq_edge_q <= 1'b1;
      else if (ack_irq)
        irq_edge_q <= 1'b0;
    end
  end

  assign pend[RK_RESET]  = ~rst_pin_n;
  assign pend[RK_CLKMON] = clkmon_fail;
  assign pend[RK_COP]    = cop_fail;
  assign pend[RK_ILLOP]  = illop_q;
  assign pend[RK_SWI]    = swi_q;
  assign pend[RK_XIRQ]   = ~xirq_n;
  assign pend[RK_IRQ]    = sense_edge ? irq_edge_q : ~irq_n;

  for (genvar gp = 0; gp < NUM_PERIPH; gp++) begin : g_per
    assign pend[RK_PER0+gp] = per_req[gp] & per_en[gp];
  end
endmodule

// File: rtl/intc_mask_ctl.sv
module intc_mask_ctl
  import intc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ccr_wr,
  input  logic  ccr_i_wd,
  input  logic  ccr_x_wd,
  input  logic  prom_wr,
  input  rank_t prom_wd,
  input  logic  sense_wr,
  input  logic  sense_wd,
  input  logic  ack,
  input  rank_t ack_src,
  output logic  mask_i,
  output logic  mask_x,
  output rank_t prom_q,
  output logic  sense_edge
);
  logic raise_x;

  assign raise_x = ack && ((ack_src <= rank_t'(RK_COP)) ||
                           (ack_src == rank_t'(RK_XIRQ)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_i <= 1'b1;
      mask_x <= 1'b1;
    end else begin
      if (ack)
        mask_i <= 1'b1;
      else if (ccr_wr)
        mask_i <= ccr_i_wd;

      if (raise_x)
        mask_x <= 1'b1;
      else if (ccr_wr)
        mask_x <= mask_x & ccr_x_wd;
    end
  end

  // promotion is only writable while maskable sources are blocked
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prom_q     <= rank_t'(RK_IRQ);
      sense_edge <= 1'b0;
    end else begin
      if (prom_wr && mask_i)
        prom_q <= prom_wd;
      if (sense_wr)
        sense_edge <= sense_wd;
    end
  end
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter
  import intc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 21
) (
  input  logic [NUM_SRC-1:0] pend,
  input  logic               mask_i,
  input  logic               mask_x,
  input  rank_t              prom,
  output logic               valid,
  output rank_t              sel
);
  logic [NUM_SRC-1:0] elig;
  logic promo_hit;
  logic fixed_any;

  for (genvar gk = 0; gk < NUM_SRC; gk++) begin : g_elig
    if (gk < RK_XIRQ) begin : g_always
      assign elig[gk] = pend[gk];
    end else if (gk == RK_XIRQ) begin : g_xgate
      assign elig[gk] = pend[gk] & ~mask_x;
    end else begin : g_igate
      assign elig[gk] = pend[gk] & ~mask_i;
    end
  end

  assign fixed_any = |elig[RK_XIRQ:0];
  assign valid     = |elig;

  always_comb begin
    promo_hit = 1'b0;
    for (int k = RK_IRQ; k < NUM_SRC; k++)
      if (prom == rank_t'(k) && elig[k])
        promo_hit = 1'b1;
  end

  always_comb begin
    sel = '0;
    for (int k = NUM_SRC - 1; k >= 0; k--)
      if (elig[k])
        sel = rank_t'(k);
    if (promo_hit && !fixed_any)
      sel = prom;
  end
endmodule

// File: rtl/intc_prio.sv
module intc_prio
  import intc_pkg::*;
#(
  parameter int unsigned NUM_PERIPH = 14,
  parameter logic [15:0] VEC_TOP    = 16'hFFFE
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rst_pin_n,
  input  logic                  clkmon_fail,
  input  logic                  cop_fail,
  input  logic                  illop_stb,
  input  logic                  swi_stb,
  input  logic                  xirq_n,
  input  logic                  irq_n,
  input  logic [NUM_PERIPH-1:0] per_req,
  input  logic [NUM_PERIPH-1:0] per_en,
  input  logic                  ccr_wr,
  input  logic                  ccr_i_wd,
  input  logic                  ccr_x_wd,
  input  logic                  prom_wr,
  input  logic [4:0]            prom_wd,
  input  logic                  sense_wr,
  input  logic                  sense_wd,
  output logic                  req_valid,
  input  logic                  req_ready,
  output logic [4:0]            req_src,
  output logic [15:0]           req_vec,
  output logic                  mask_i,
  output logic                  mask_x
);
  localparam int unsigned NUM_SRC = RK_PER0 + NUM_PERIPH;

  logic [NUM_SRC-1:0] pend;
  logic               sense_edge;
  logic               ack;
  rank_t              prom_q;
  rank_t              sel;

  assign ack = req_valid & req_ready;

  intc_pending #(.NUM_PERIPH(NUM_PERIPH)) u_pend (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_pin_n  (rst_pin_n),
    .clkmon_fail(clkmon_fail),
    .cop_fail   (cop_fail),
    .illop_stb  (illop_stb),
    .swi_stb    (swi_stb),
    .xirq_n     (xirq_n),
    .irq_n      (irq_n),
    .per_req    (per_req),
    .per_en     (per_en),
    .sense_edge (sense_edge),
    .ack        (ack),
    .ack_src    (sel),
    .pend       (pend)
  );

  intc_mask_ctl u_mask (
    .clk       (clk),
    .rst_n     (rst_n),
    .ccr_wr    (ccr_wr),
    .ccr_i_wd  (ccr_i_wd),
    .ccr_x_wd  (ccr_x_wd),
    .prom_wr   (prom_wr),
    .prom_wd   (rank_t'(prom_wd)),
    .sense_wr  (sense_wr),
    .sense_wd  (sense_wd),
    .ack       (ack),
    .ack_src   (sel),
    .mask_i    (mask_i),
    .mask_x    (mask_x),
    .prom_q    (prom_q),
    .sense_edge(sense_edge)
  );

  intc_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
    .pend  (pend),
    .mask_i(mask_i),
    .mask_x(mask_x),
    .prom  (prom_q),
    .valid (req_valid),
    .sel   (sel)
  );

  assign req_src = sel;
  assign req_vec = vec_of(VEC_TOP, sel);
endmodule

// File: rtl/intc_prio_chk.sv
module intc_prio_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic [4:0]  req_src,
  input logic [15:0] req_vec,
  input logic        mask_i,
  input logic        mask_x,
  input logic        prom_wr,
  input logic [4:0]  prom_q
);
  // R7
  x_only_hw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mask_x) |-> $past(req_valid && req_ready && (req_src <= 5'd2 || req_src == 5'd5)));

  // R4
  maskable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_src >= 5'd6) |-> !mask_i);

  // R7
  xirq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_src == 5'd5) |-> !mask_x);

  // R8
  ack_sets_i_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> mask_i);

  // R5
  prom_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prom_wr && !mask_i) |=> $stable(prom_q));

  // R2
  irq_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_src == 5'd6) |-> req_vec == 16'hFFF2);
endmodule

bind intc_prio intc_prio_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .req_src  (req_src),
  .req_vec  (req_vec),
  .mask_i   (mask_i),
  .mask_x   (mask_x),
  .prom_wr  (prom_wr),
  .prom_q   (prom_q)
);

// File: tb/intc_prio_test.sv
`timescale 1ns/1ps
module intc_prio_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rst_pin_n = 1'b1, clkmon_fail = 1'b0, cop_fail = 1'b0;
  logic illop_stb = 1'b0, swi_stb = 1'b0, xirq_n = 1'b1, irq_n = 1'b1;
  logic [13:0] per_req = '0, per_en = '0;
  logic ccr_wr = 1'b0, ccr_i_wd = 1'b1, ccr_x_wd = 1'b1;
  logic prom_wr = 1'b0;
  logic [4:0] prom_wd = '0;
  logic sense_wr = 1'b0, sense_wd = 1'b0;
  logic req_valid, req_ready = 1'b0;
  logic [4:0] req_src;
  logic [15:0] req_vec;
  logic mask_i, mask_x;

  int nchk = 0, nerr = 0;
  bit done = 1'b0;
  int exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  intc_prio uut (
    .clk(clk), .rst_n(rst_n), .rst_pin_n(rst_pin_n), .clkmon_fail(clkmon_fail),
    .cop_fail(cop_fail), .illop_stb(illop_stb), .swi_stb(swi_stb),
    .xirq_n(xirq_n), .irq_n(irq_n), .per_req(per_req), .per_en(per_en),
    .ccr_wr(ccr_wr), .ccr_i_wd(ccr_i_wd), .ccr_x_wd(ccr_x_wd),
    .prom_wr(prom_wr), .prom_wd(prom_wd), .sense_wr(sense_wr), .sense_wd(sense_wd),
    .req_valid(req_valid), .req_ready(req_ready), .req_src(req_src),
    .req_vec(req_vec), .mask_i(mask_i), .mask_x(mask_x)
  );

  task automatic check(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // scoreboard driver: queue the expected rank, then take the request
  task automatic grant(input int src, input string tag);
    step();
    exp_q.push_back(src);
    tag_q.push_back(tag);
    req_ready = 1'b1;
    step();
    req_ready = 1'b0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (req_ready) begin
      if (exp_q.size() == 0) begin
        nchk++; nerr++;
        $display("FAIL R12 unexpected take actual=%0d expected=none", req_src);
      end else begin
        int e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({t, " valid"}, int'(req_valid), 1);
        check({t, " rank"}, int'(req_src), e);
        check({t, " R2 vector"}, int'(req_vec), 32'hFFFE - 2 * e);
      end
    end
  end

  task automatic ccr_write(input logic i, input logic x);
    step();
    ccr_wr = 1'b1; ccr_i_wd = i; ccr_x_wd = x;
    step();
    ccr_wr = 1'b0;
    #1;
  endtask

  task automatic prom_write(input int r);
    step();
    prom_wr = 1'b1; prom_wd = 5'(r);
    step();
    prom_wr = 1'b0;
    #1;
  endtask

  task automatic sense_write(input logic e);
    step();
    sense_wr = 1'b1; sense_wd = e;
    step();
    sense_wr = 1'b0;
    #1;
  endtask

  initial begin
    #(20000 * 5);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    step(); step();
    rst_n = 1'b1;
    step();
    // R1 reset state
    check("R1 valid", int'(req_valid), 0);
    check("R1 mask_i", int'(mask_i), 1);
    check("R1 mask_x", int'(mask_x), 1);

    // R4 peripheral blocked while I=1
    per_req[0] = 1'b1; per_en[0] = 1'b1;
    #1 check("R4 masked by I", int'(req_valid), 0);

    // R5 promotion of rank 19 overtakes rank 7
    prom_write(19);
    ccr_write(1'b0, 1'b1);
    per_req[12] = 1'b1; per_en[12] = 1'b1;
    #1 check("R5 promoted offered", int'(req_src), 19);
    grant(19, "R5 promoted");
    check("R8 I set on maskable", int'(mask_i), 1);
    check("R8 X unchanged on maskable", int'(mask_x), 1);
    ccr_write(1'b0, 1'b1);
    per_req[12] = 1'b0;
    grant(7, "R3 rank 7");

    // R5 write while I=0 ignored: rank 8 must beat rank 20
    ccr_write(1'b0, 1'b1);
    prom_write(20);
    per_req = '0;
    per_req[1] = 1'b1; per_en[1] = 1'b1;
    per_req[13] = 1'b1; per_en[13] = 1'b1;
    grant(8, "R5 locked write");
    per_req = '0;

    // R4 local enable
    ccr_write(1'b0, 1'b1);
    per_req[2] = 1'b1; per_en[2] = 1'b0;
    #1 check("R4 local enable off", int'(req_valid), 0);
    per_en[2] = 1'b1;
    grant(9, "R4 local enable on");
    per_req = '0;

    // R6 non-maskable code means no promotion
    prom_write(3);
    ccr_write(1'b0, 1'b1);
    per_req[12] = 1'b1; per_req[0] = 1'b1;
    grant(7, "R6 no promotion");
    per_req = '0;

    // R7 XIRQ gated by X, one-way clear
    xirq_n = 1'b0;
    ccr_write(1'b0, 1'b1);
    #1 check("R7 xirq masked", int'(req_valid), 0);
    ccr_write(1'b1, 1'b0);
    irq_n = 1'b0;
    grant(5, "R7 xirq after clear");
    check("R8 X set by xirq", int'(mask_x), 1);
    check("R8 I set by xirq", int'(mask_i), 1);
    xirq_n = 1'b1;
    ccr_write(1'b1, 1'b0);
    ccr_write(1'b1, 1'b1);
    check("R7 X cannot be set", int'(mask_x), 0);

    // R3 xirq over irq; R10 level re-request
    ccr_write(1'b0, 1'b0);
    xirq_n = 1'b0;
    grant(5, "R3 xirq over irq");
    xirq_n = 1'b1;
    ccr_write(1'b0, 1'b0);
    grant(6, "R10 level irq");
    ccr_write(1'b0, 1'b0);
    check("R10 re-request", int'(req_valid), 1);
    check("R10 re-request rank", int'(req_src), 6);
    irq_n = 1'b1;
    #1 check("R10 released", int'(req_valid), 0);

    // R11 edge mode
    sense_write(1'b1);
    irq_n = 1'b0;
    #1 check("R11 before latch", int'(req_valid), 0);
    step();
    check("R11 after edge", int'(req_src), 6);
    grant(6, "R11 edge irq");
    ccr_write(1'b0, 1'b0);
    check("R11 no re-request", int'(req_valid), 0);
    irq_n = 1'b1; step();
    irq_n = 1'b0; step();
    grant(6, "R11 second edge");
    irq_n = 1'b1;

    // R9 traps regardless of I; R12 pulses held
    step(); swi_stb = 1'b1; step(); swi_stb = 1'b0;
    #1 check("R9 swi with I set", int'(req_src), 4);
    grant(4, "R9 swi");
    step(); swi_stb = 1'b1; illop_stb = 1'b1; step(); swi_stb = 1'b0; illop_stb = 1'b0;
    step(); step();
    check("R12 held valid", int'(req_valid), 1);
    check("R12 held rank", int'(req_src), 3);
    grant(3, "R12 illop");
    grant(4, "R12 swi after illop");
    check("R12 drained", int'(req_valid), 0);
    cop_fail = 1'b1;
    grant(2, "R9 cop");
    cop_fail = 1'b0;
    check("R8 X set by cop", int'(mask_x), 1);
    rst_pin_n = 1'b0; clkmon_fail = 1'b1;
    grant(0, "R3 reset pin");
    rst_pin_n = 1'b1;
    grant(1, "R3 clock monitor");
    clkmon_fail = 1'b0;
    #1 check("R12 idle at end", int'(req_valid), 0);
    check("R12 scoreboard empty", exp_q.size(), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule